// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns a segment-relative reference into a flat 20-bit physical address. It holds four 16-bit segment registers and a 16-bit instruction pointer. Software-visible state changes only through the write and pointer ports. For a data reference, the caller supplies:

- an addressing-mode code,
- a base register value, with a flag saying whether the base is the stack-frame pointer,
- an index register value,
- a displacement,
- an optional segment override.

From these the unit forms the 16-bit effective address and chooses a segment. It then adds the segment value, scaled by sixteen, to the offset. The result is the data physical address.

In parallel, the unit always produces the instruction-fetch address from the code segment and the instruction pointer. The pointer can be advanced by an instruction length or loaded with a jump target.

The data path is purely combinational from the current register contents and the request inputs. The segment registers and the instruction pointer update on the clock edge after a write.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment << 4) + offset, truncated to 20 bits. Examples: 0x0400:0x0056 gives 0x04056, and 0x05C0:0x0050 gives 0x05C50.
- R2: `fetch_addr` is always formed from the code segment and the instruction pointer, whatever the override and mode inputs are.
- R3: `ea_mode` selects the offset as follows: 0 base, 1 index, 2 base+disp, 3 index+disp, 4 base+index, 5 base+index+disp, 6 and 7 disp only.
- R4: The effective-address sum is truncated to 16 bits, so it wraps within the segment (0xFFF0 + 0x0020 gives 0x0010).
- R5: Without an override, data references use the data segment. The exception is when `base_is_bp` is set and the mode uses the base (modes 0, 2, 4, 5); then the stack segment is used. In the other modes `base_is_bp` has no effect.
- R6: When `ovr_valid` is high, `ovr_idx` replaces the default data segment.
- R7: Segment register indices are 0 extra, 1 code, 2 stack, 3 data, and this is also the `data_seg` encoding. A write with `seg_wr_en` takes effect at the next clock edge.
- R8: `ip_adv` adds `ip_adv_len` to the pointer, modulo 2^16, when the length is 1 to 6. Lengths 0 and 7 leave the pointer unchanged.
- R9: `ip_load` loads `ip_load_val` and takes precedence over a simultaneous advance.
- R10: After reset, all segment registers and the instruction pointer are zero.
- R11: A physical sum past 0xFFFFF wraps (0xFFFF:0x0020 gives 0x00010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Write a segment register |
| seg_wr_idx | input | 2 | Segment register index |
| seg_wr_data | input | 16 | Segment value to write |
| ip_load | input | 1 | Load instruction pointer |
| ip_load_val | input | 16 | Jump target |
| ip_adv | input | 1 | Advance instruction pointer |
| ip_adv_len | input | 3 | Instruction length in bytes |
| ea_mode | input | 3 | Effective-address mode code |
| base_val | input | 16 | Base register value |
| base_is_bp | input | 1 | Base is the stack-frame pointer |
| index_val | input | 16 | Index register value |
| disp_val | input | 16 | Displacement |
| ovr_valid | input | 1 | Segment override present |
| ovr_idx | input | 2 | Override segment index |
| ea_out | output | 16 | Effective address |
| data_seg | output | 2 | Segment index used for the data reference |
| data_addr | output | 20 | Data physical address |
| fetch_addr | output | 20 | Instruction-fetch physical address |
| ip_out | output | 16 | Current instruction pointer |

## Verification
The bench builds the block with its default parameters: 16-bit offsets, a 4-bit segment shift and a 3-bit length field. At these values both wrap boundaries, 0xFFFF in the offset and 0xFFFFF in the physical address, can be reached with a handful of register writes. The same holds for the pointer wrap from 0xFFFE. At these widths every mode code and every segment index can be driven exhaustively.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        EA_B     = 3'd0,
        EA_I     = 3'd1,
        EA_BD    = 3'd2,
        EA_ID    = 3'd3,
        EA_BI    = 3'd4,
        EA_BID   = 3'd5,
        EA_D     = 3'd6,
        EA_D_ALT = 3'd7
    } ea_mode_e;

    localparam int NUM_SEG = 4;
endpackage

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int OFF_W = 16
) (
    input  logic [2:0]       mode,
    input  logic [OFF_W-1:0] base,
    input  logic [OFF_W-1:0] index,
    input  logic [OFF_W-1:0] disp,
    output logic [OFF_W-1:0] ea,
    output logic             uses_base
);
    import seg_addr_pkg::*;

    logic use_b, use_i, use_d;

    always_comb begin
        use_b = 1'b0;
        use_i = 1'b0;
        use_d = 1'b0;
        unique case (ea_mode_e'(mode))
            EA_B:    use_b = 1'b1;
            EA_I:    use_i = 1'b1;
            EA_BD:   begin use_b = 1'b1; use_d = 1'b1; end
            EA_ID:   begin use_i = 1'b1; use_d = 1'b1; end
            EA_BI:   begin use_b = 1'b1; use_i = 1'b1; end
            EA_BID:  begin use_b = 1'b1; use_i = 1'b1; use_d = 1'b1; end
            default: use_d = 1'b1;
        endcase
        // sum is kept to OFF_W bits: offsets wrap inside the segment
        ea = (use_b ? base : '0) + (use_i ? index : '0) + (use_d ? disp : '0);
        uses_base = use_b;
    end
endmodule

// File: rtl/seg_pick.sv
module seg_pick (
    input  logic       uses_base,
    input  logic       base_is_bp,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_idx,
    output logic [1:0] seg_idx
);
    import seg_addr_pkg::*;

    always_comb begin
        if (ovr_valid)
            seg_idx = ovr_idx;
        else if (uses_base && base_is_bp)
            seg_idx = SEG_STACK;
        else
            seg_idx = SEG_DATA;
    end
endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = OFF_W + SHIFT
) (
    input  logic [OFF_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    always_comb begin
        // carry out of the top bit is dropped: wraps at the top of the space
        phys = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int LEN_W = 3,
    parameter int MAX_LEN = 6,
    localparam int PA_W = OFF_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_idx,
    input  logic [OFF_W-1:0] seg_wr_data,
    input  logic             ip_load,
    input  logic [OFF_W-1:0] ip_load_val,
    input  logic             ip_adv,
    input  logic [LEN_W-1:0] ip_adv_len,
    input  logic [2:0]       ea_mode,
    input  logic [OFF_W-1:0] base_val,
    input  logic             base_is_bp,
    input  logic [OFF_W-1:0] index_val,
    input  logic [OFF_W-1:0] disp_val,
    input  logic             ovr_valid,
    input  logic [1:0]       ovr_idx,
    output logic [OFF_W-1:0] ea_out,
    output logic [1:0]       data_seg,
    output logic [PA_W-1:0]  data_addr,
    output logic [PA_W-1:0]  fetch_addr,
    output logic [OFF_W-1:0] ip_out
);
    import seg_addr_pkg::*;

    typedef struct packed {
        logic [NUM_SEG-1:0][OFF_W-1:0] seg;
        logic [OFF_W-1:0]              ip;
    } regs_t;

    regs_t st_d, st_q;
    logic  uses_base;
    logic  len_ok;

    always_comb begin
        st_d   = st_q;
        len_ok = (ip_adv_len != '0) && (int'(ip_adv_len) <= MAX_LEN);
        if (seg_wr_en)
            st_d.seg[seg_wr_idx] = seg_wr_data;
        if (ip_load)
            st_d.ip = ip_load_val;
        else if (ip_adv && len_ok)
            st_d.ip = st_q.ip + OFF_W'(ip_adv_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    ea_gen #(.OFF_W(OFF_W)) u_ea (
        .mode      (ea_mode),
        .base      (base_val),
        .index     (index_val),
        .disp      (disp_val),
        .ea        (ea_out),
        .uses_base (uses_base)
    );

    seg_pick u_pick (
        .uses_base  (uses_base),
        .base_is_bp (base_is_bp),
        .ovr_valid  (ovr_valid),
        .ovr_idx    (ovr_idx),
        .seg_idx    (data_seg)
    );

    phys_adder #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_data_pa (
        .seg  (st_q.seg[data_seg]),
        .off  (ea_out),
        .phys (data_addr)
    );

    phys_adder #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_fetch_pa (
        .seg  (st_q.seg[SEG_CODE]),
        .off  (st_q.ip),
        .phys (fetch_addr)
    );

    assign ip_out = st_q.ip;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int LEN_W = 3,
    parameter int MAX_LEN = 6,
    localparam int PA_W = OFF_W + SHIFT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_wr_en,
    input logic [1:0]       seg_wr_idx,
    input logic [OFF_W-1:0] seg_wr_data,
    input logic             ip_load,
    input logic [OFF_W-1:0] ip_load_val,
    input logic             ip_adv,
    input logic [LEN_W-1:0] ip_adv_len,
    input logic             ovr_valid,
    input logic [1:0]       ovr_idx,
    input logic [2:0]       ea_mode,
    input logic             base_is_bp,
    input logic [1:0]       data_seg,
    input logic [PA_W-1:0]  fetch_addr,
    input logic [OFF_W-1:0] ip_out
);
    // R6
    ovr_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> data_seg == ovr_idx);

    // R5
    dflt_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && !base_is_bp) |-> data_seg == 2'd3);

    // R5
    bp_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && (ea_mode == 3'd1 || ea_mode == 3'd3)) |-> data_seg == 2'd3);

    // R9
    ip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> ip_out == $past(ip_load_val));

    // R8
    ip_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip_load && ip_adv && ip_adv_len != '0 && int'(ip_adv_len) <= MAX_LEN)
        |=> ip_out == $past(ip_out) + OFF_W'($past(ip_adv_len)));

    // R8
    ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip_load && !ip_adv) |=> $stable(ip_out));

    // R2
    cs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_wr_en && seg_wr_idx == 2'd1) |=>
        fetch_addr == ({$past(seg_wr_data), {SHIFT{1'b0}}} + PA_W'(ip_out)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
    .OFF_W(OFF_W), .SHIFT(SHIFT), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
    .seg_wr_data(seg_wr_data), .ip_load(ip_load), .ip_load_val(ip_load_val),
    .ip_adv(ip_adv), .ip_adv_len(ip_adv_len), .ovr_valid(ovr_valid),
    .ovr_idx(ovr_idx), .ea_mode(ea_mode), .base_is_bp(base_is_bp),
    .data_seg(data_seg), .fetch_addr(fetch_addr), .ip_out(ip_out)
);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_idx = '0;
    logic [15:0] seg_wr_data = '0;
    logic        ip_load = 1'b0;
    logic [15:0] ip_load_val = '0;
    logic        ip_adv = 1'b0;
    logic [2:0]  ip_adv_len = '0;
    logic [2:0]  ea_mode = '0;
    logic [15:0] base_val = '0;
    logic        base_is_bp = 1'b0;
    logic [15:0] index_val = '0;
    logic [15:0] disp_val = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_idx = '0;
    logic [15:0] ea_out;
    logic [1:0]  data_seg;
    logic [19:0] data_addr;
    logic [19:0] fetch_addr;
    logic [15:0] ip_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    seg_addr_gen dut (.*);

    task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %05h expected %05h", req, got, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] idx, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_idx = idx; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic ip_step(input logic ld, input logic [15:0] v, input logic adv, input logic [2:0] len);
        @(negedge clk);
        ip_load = ld; ip_load_val = v; ip_adv = adv; ip_adv_len = len;
        @(negedge clk);
        ip_load = 1'b0; ip_adv = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 ip", 20'(ip_out), 20'h0);
        chk("R10 fetch", fetch_addr, 20'h0);
        ea_mode = 3'd6; disp_val = 16'h1234; #1;
        chk("R10 data seg zero", data_addr, 20'h01234);
    endtask

    task automatic t_examples();
        wr_seg(2'd1, 16'h0400);
        ip_step(1'b1, 16'h0056, 1'b0, 3'd0);
        chk("R1 R7 fetch example", fetch_addr, 20'h04056);
        wr_seg(2'd3, 16'h05C0);
        ea_mode = 3'd6; disp_val = 16'h0050; #1;
        chk("R1 data example", data_addr, 20'h05C50);
    endtask

    task automatic t_modes();
        logic [15:0] exp [8] = '{16'h1000, 16'h0200, 16'h1034, 16'h0234,
                                 16'h1200, 16'h1234, 16'h0034, 16'h0034};
        base_val = 16'h1000; index_val = 16'h0200; disp_val = 16'h0034;
        for (int m = 0; m < 8; m++) begin
            ea_mode = 3'(m); #1;
            chk($sformatf("R3 mode %0d", m), 20'(ea_out), 20'(exp[m]));
        end
        ea_mode = 3'd4; base_val = 16'hFFF0; index_val = 16'h0020; #1;
        chk("R4 ea wrap", 20'(ea_out), 20'h00010);
    endtask

    task automatic t_default_seg();
        wr_seg(2'd2, 16'h2000);
        base_val = 16'h0010; index_val = 16'h0004; disp_val = 16'h0;
        base_is_bp = 1'b0; ea_mode = 3'd0; #1;
        chk("R5 default data", 20'(data_seg), 20'd3);
        base_is_bp = 1'b1; #1;
        chk("R5 bp base stack", 20'(data_seg), 20'd2);
        chk("R5 R7 stack addr", data_addr, 20'h20010);
        ea_mode = 3'd5; #1;
        chk("R5 bp base+index", 20'(data_seg), 20'd2);
        ea_mode = 3'd1; #1;
        chk("R5 bp ignored index mode", 20'(data_seg), 20'd3);
        chk("R5 index addr", data_addr, 20'h05C04);
        base_is_bp = 1'b0;
    endtask

    task automatic t_override();
        wr_seg(2'd0, 16'h3000);
        ea_mode = 3'd0; base_val = 16'h0008; base_is_bp = 1'b1;
        ovr_valid = 1'b1; ovr_idx = 2'd0; #1;
        chk("R6 override seg", 20'(data_seg), 20'd0);
        chk("R6 override addr", data_addr, 20'h30008);
        chk("R2 fetch ignores override", fetch_addr, 20'h04056);
        ovr_idx = 2'd1; #1;
        chk("R6 override code", data_addr, 20'h04008);
        ovr_valid = 1'b0; base_is_bp = 1'b0;
    endtask

    task automatic t_wrap();
        wr_seg(2'd3, 16'hFFFF);
        ea_mode = 3'd6; disp_val = 16'h0020; #1;
        chk("R11 phys wrap", data_addr, 20'h00010);
    endtask

    task automatic t_ip();
        ip_step(1'b1, 16'h0100, 1'b0, 3'd0);
        chk("R9 load", 20'(ip_out), 20'h00100);
        ip_step(1'b0, 16'h0, 1'b1, 3'd6);
        chk("R8 adv 6", 20'(ip_out), 20'h00106);
        ip_step(1'b0, 16'h0, 1'b1, 3'd1);
        chk("R8 adv 1", 20'(ip_out), 20'h00107);
        ip_step(1'b0, 16'h0, 1'b1, 3'd0);
        chk("R8 len 0 ignored", 20'(ip_out), 20'h00107);
        ip_step(1'b0, 16'h0, 1'b1, 3'd7);
        chk("R8 len 7 ignored", 20'(ip_out), 20'h00107);
        ip_step(1'b1, 16'h0200, 1'b1, 3'd4);
        chk("R9 load beats adv", 20'(ip_out), 20'h00200);
        ip_step(1'b1, 16'hFFFE, 1'b0, 3'd0);
        ip_step(1'b0, 16'h0, 1'b1, 3'd3);
        chk("R8 ip wrap", 20'(ip_out), 20'h00001);
        chk("R2 fetch after wrap", fetch_addr, 20'h04001);
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_examples();
        t_modes();
        t_default_seg();
        t_override();
        t_wrap();
        t_ip();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule